// File: doc/BRIEF.md
# Bit-6 Address Channel Swizzler

This block rewrites byte addresses so that an agent writing memory linearly sees the same channel interleave as a tiled reader. On interleaved two-channel memory, address bit 6 picks the channel for each 64-byte block. A tiled reader also folds higher address bits into that choice, so a linear writer must fold in the same bits. The block has two parts. A mode selector decodes a memory configuration word into one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces. A one-stage datapath XORs the chosen higher bits into bit 6 and reports the mode that applied.

The configuration word is captured only in a cycle where `cfg_load` is high, and the captured modes hold until the next load. Addresses enter on a valid/ready stream together with a tiling kind, and leave one cycle later on a second valid/ready stream. A beat moves on an edge where both valid and ready are high. Once `out_valid` is high, the output payload holds steady until `out_ready` takes it. `in_ready` falls only while a result is waiting and `out_ready` is low, so back-pressure reaches the input in the same cycle. With `out_ready` held high, one address is accepted on every clock.

Top module: `bit6_swizzler`

## Requirements
- R1: After reset, and before the first configuration load, both captured modes are UNKNOWN. A tiled request therefore leaves unchanged, with out_mode NONE.
- R2: A configuration word of all ones selects UNKNOWN for both X and Y. Tiled requests are then treated as untiled: the address is unchanged and out_mode is NONE.
- R3: A request whose tiling kind is 0 (linear) or 3 (reserved, treated as linear) always leaves unchanged, with out_mode NONE, whatever the captured modes are.
- R4: Configuration layout field cfg_word[1:0] = 0 (single channel) or 1 (dual channel, asymmetric) selects NONE for X (tiling 1) and Y (tiling 2). The address passes through unchanged.
- R5: Layout 2 (dual channel, interleaved) with cfg_word[2] = 1 (CPU-side XOR off) selects mode 9_10 for X and mode 9 for Y. Mode codes on out_mode are NONE=0, 9=1, 9_10=2, 9_11=3, 9_10_11=4, 9_17=5, 9_10_17=6, UNKNOWN=7.
- R6: Layout 2 with cfg_word[2] = 0 and cfg_word[3] = 0 selects 9_10_11 for X and 9_11 for Y.
- R7: Layout 2 with cfg_word[2] = 0 and cfg_word[3] = 1 selects 9_10_17 for X and 9_17 for Y. The datapath folds bit 17 into bit 6, but out_mode reports 9_10 (2) and 9 (1) in place of those modes.
- R8: Layout 3 (size-matched) compares the channel size fields cfg_word[15:8] and cfg_word[23:16]. If they are equal it selects 9_10 for X and 9 for Y. If they differ it selects NONE.
- R9: The modes change only on a clock edge where cfg_load is high. A change of cfg_word without a load has no effect. A request accepted on the same edge as a load uses the modes that applied before that load.
- R10: A request accepted on one edge appears on the output after that edge. While out_valid is high and out_ready is low, in_ready is low and out_addr and out_mode hold.
- R11: With out_ready held high, in_ready stays high and a request is accepted on every clock with no bubbles.
- R12: Only bit 6 of the address can change. Bit 6 becomes the XOR of input bit 6 with each of input bits 9, 10, 11 and 17 that the applied mode names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture cfg_word into the mode selector on this edge |
| cfg_word | input | CFG_W | Memory configuration word |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Block can accept an input address |
| in_addr | input | AW | Byte address from the linear writer |
| in_tiling | input | 2 | Tiling kind: 0 linear, 1 X, 2 Y, 3 treated as linear |
| out_valid | output | 1 | Rewritten address valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_addr | output | AW | Rewritten address |
| out_mode | output | 3 | Reported swizzle mode that applied |

## Verification
The reference model applies every configuration class: single and asymmetric layouts, interleaved with the CPU XOR off, folding bit 11, and folding bit 17, size-matched with equal and with differing sizes, and the all-ones word. Under each class it sends X, Y, linear and reserved requests. Addresses sweep all sixteen combinations of bits 9, 10, 11 and 17 over random backgrounds. This separates which taps each mode folds in, and checks that nothing outside bit 6 changes. Loads with and without a cfg_word change, and a load that falls on the same edge as a request, show when the modes take effect. Bursts with a stalling consumer and with a free-running consumer show that the output holds under back-pressure and that no bubbles appear.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_B9       = 3'd1,
    SWZ_B9_10    = 3'd2,
    SWZ_B9_11    = 3'd3,
    SWZ_B9_10_11 = 3'd4,
    SWZ_B9_17    = 3'd5,
    SWZ_B9_10_17 = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_kind_e;

  // layout field codes in the configuration word
  localparam logic [1:0] LAYOUT_SINGLE  = 2'd0;
  localparam logic [1:0] LAYOUT_ASYM    = 2'd1;
  localparam logic [1:0] LAYOUT_INTLV   = 2'd2;
  localparam logic [1:0] LAYOUT_MATCHED = 2'd3;

  localparam int LAYOUT_LSB = 0;
  localparam int XOR_OFF_BIT = 2;
  localparam int XOR_HI_BIT = 3;

  // bit-17 modes are reported as their lower-bit counterparts
  function automatic swz_mode_e report_mode(swz_mode_e m);
    case (m)
      SWZ_B9_17:    return SWZ_B9;
      SWZ_B9_10_17: return SWZ_B9_10;
      default:      return m;
    endcase
  endfunction

endpackage

// File: rtl/swz_mode_select.sv
module swz_mode_select
  import swz_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int SZ_W    = 8,
  parameter int SZ0_LSB = 8,
  parameter int SZ1_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  output swz_mode_e        mode_x,
  output swz_mode_e        mode_y
);

  logic [1:0]      layout;
  logic [SZ_W-1:0] size_a;
  logic [SZ_W-1:0] size_b;
  swz_mode_e       dec_x;
  swz_mode_e       dec_y;

  assign layout = cfg[LAYOUT_LSB +: 2];
  assign size_a = cfg[SZ0_LSB +: SZ_W];
  assign size_b = cfg[SZ1_LSB +: SZ_W];

  always_comb begin
    dec_x = SWZ_NONE;
    dec_y = SWZ_NONE;
    if (&cfg) begin
      dec_x = SWZ_UNKNOWN;
      dec_y = SWZ_UNKNOWN;
    end else begin
      case (layout)
        LAYOUT_INTLV: begin
          if (cfg[XOR_OFF_BIT]) begin
            dec_x = SWZ_B9_10;
            dec_y = SWZ_B9;
          end else if (!cfg[XOR_HI_BIT]) begin
            dec_x = SWZ_B9_10_11;
            dec_y = SWZ_B9_11;
          end else begin
            dec_x = SWZ_B9_10_17;
            dec_y = SWZ_B9_17;
          end
        end
        LAYOUT_MATCHED: begin
          if (size_a == size_b) begin
            dec_x = SWZ_B9_10;
            dec_y = SWZ_B9;
          end
        end
        default: begin
          dec_x = SWZ_NONE;
          dec_y = SWZ_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_x <= SWZ_UNKNOWN;
      mode_y <= SWZ_UNKNOWN;
    end else if (load) begin
      mode_x <= dec_x;
      mode_y <= dec_y;
    end
  end

endmodule

// File: rtl/swz_xor_fold.sv
module swz_xor_fold
  import swz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  swz_mode_e     mode_i,
  output logic [AW-1:0] addr_o,
  output swz_mode_e     mode_o
);

  localparam int NTAP = 4;
  localparam int TAP_POS [NTAP] = '{9, 10, 11, 17};
  localparam int DST = 6;

  logic [NTAP-1:0] tap_en;
  logic [NTAP-1:0] tap_hit;

  // tap_en bit order follows TAP_POS: {17, 11, 10, 9}
  always_comb begin
    case (mode_i)
      SWZ_B9:       tap_en = 4'b0001;
      SWZ_B9_10:    tap_en = 4'b0011;
      SWZ_B9_11:    tap_en = 4'b0101;
      SWZ_B9_10_11: tap_en = 4'b0111;
      SWZ_B9_17:    tap_en = 4'b1001;
      SWZ_B9_10_17: tap_en = 4'b1011;
      default:      tap_en = 4'b0000;
    endcase
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap_hit[g] = tap_en[g] & addr_i[TAP_POS[g]];
  end

  always_comb begin
    addr_o      = addr_i;
    addr_o[DST] = addr_i[DST] ^ (^tap_hit);
  end

  assign mode_o = report_mode(mode_i);

endmodule

// File: rtl/swz_pipe_stage.sv
module swz_pipe_stage #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

endmodule

// File: rtl/bit6_swizzler.sv
module bit6_swizzler
  import swz_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CFG_W   = 32,
  parameter int SZ_W    = 8,
  parameter int SZ0_LSB = 8,
  parameter int SZ1_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_addr,
  input  logic [1:0]       in_tiling,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_addr,
  output logic [2:0]       out_mode
);

  localparam int MW = 3;
  localparam int PW = AW + MW;

  swz_mode_e       mode_x;
  swz_mode_e       mode_y;
  swz_mode_e       eff_mode;
  swz_mode_e       rep_mode;
  logic [AW-1:0]   folded;
  logic [PW-1:0]   pay_in;
  logic [PW-1:0]   pay_out;

  swz_mode_select #(
    .CFG_W(CFG_W), .SZ_W(SZ_W), .SZ0_LSB(SZ0_LSB), .SZ1_LSB(SZ1_LSB)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .cfg(cfg_word),
    .mode_x(mode_x), .mode_y(mode_y)
  );

  // pick the mode for this request; unknown falls back to untiled
  always_comb begin
    case (tile_kind_e'(in_tiling))
      TILE_X:  eff_mode = mode_x;
      TILE_Y:  eff_mode = mode_y;
      default: eff_mode = SWZ_NONE;
    endcase
    if (eff_mode == SWZ_UNKNOWN) eff_mode = SWZ_NONE;
  end

  swz_xor_fold #(.AW(AW)) u_fold (
    .addr_i(in_addr), .mode_i(eff_mode), .addr_o(folded), .mode_o(rep_mode)
  );

  assign pay_in = {rep_mode, folded};

  swz_pipe_stage #(.W(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(pay_in),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(pay_out)
  );

  assign out_addr = pay_out[AW-1:0];
  assign out_mode = pay_out[PW-1:AW];

endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] in_addr,
  input logic [1:0]    in_tiling,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [2:0]    out_mode
);

  localparam logic [AW-1:0] KEEP = ~(AW'(1) << 6);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_mode)))
    else $error("output changed while stalled");

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("input ready while output stalled");

  assert_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted request missing at output");

  assert_only_bit6_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (((out_addr ^ $past(in_addr)) & KEEP) == '0))
    else $error("bit other than 6 changed");

  assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_tiling == 2'd0 || in_tiling == 2'd3))
    |=> (out_mode == 3'd0 && out_addr == $past(in_addr)))
    else $error("linear request altered");

  assert_no_hidden_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode != 3'd5 && out_mode != 3'd6 && out_mode != 3'd7))
    else $error("bit-17 or unknown mode reported");

endmodule

bind bit6_swizzler swz_checker #(.AW(AW)) u_swz_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_tiling(in_tiling), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_mode(out_mode)
);

// File: tb/bit6_swizzler_bench.sv
module bit6_swizzler_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [CW-1:0] cfg_word = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tiling = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [2:0]    out_mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // model state
  int mdl_x = 7;
  int mdl_y = 7;
  logic [AW+2:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bit6_swizzler u_bit6_swizzler (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_tiling(in_tiling), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_mode(out_mode)
  );

  function automatic logic [CW-1:0] mkcfg(int layout, int xoff, int hi, int s0, int s1);
    logic [CW-1:0] w = '0;
    w[1:0] = layout[1:0];
    w[2] = xoff[0];
    w[3] = hi[0];
    w[15:8] = s0[7:0];
    w[23:16] = s1[7:0];
    return w;
  endfunction

  // returns x mode in [3:0], y mode in [7:4]
  function automatic int decode(logic [CW-1:0] w);
    if (w == '1) return 7 | (7 << 4);
    if (w[1:0] == 2'd2) begin
      if (w[2]) return 2 | (1 << 4);
      if (!w[3]) return 4 | (3 << 4);
      return 6 | (5 << 4);
    end
    if (w[1:0] == 2'd3 && w[15:8] == w[23:16]) return 2 | (1 << 4);
    return 0;
  endfunction

  function automatic logic [AW+2:0] expect_of(logic [AW-1:0] a, logic [1:0] t);
    int m;
    logic p;
    int rep;
    if (t == 2'd1) m = mdl_x; else if (t == 2'd2) m = mdl_y; else m = 0;
    if (m == 7) m = 0;
    p = a[6];
    if (m >= 1 && m <= 6) p = p ^ a[9];
    if (m == 2 || m == 4 || m == 6) p = p ^ a[10];
    if (m == 3 || m == 4) p = p ^ a[11];
    if (m == 5 || m == 6) p = p ^ a[17];
    rep = (m == 5) ? 1 : (m == 6) ? 2 : m;
    a[6] = p;
    return {rep[2:0], a};
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit iv, logic [AW-1:0] ia, logic [1:0] it, bit ordy, bit ld, logic [CW-1:0] cw);
    bit fin, fout;
    int d;
    @(negedge clk);
    cfg_load = ld; cfg_word = cw;
    in_valid = iv; in_addr = ia; in_tiling = it; out_ready = ordy;
    #1;
    chk(out_valid == (q.size() != 0), "out_valid", out_valid, q.size() != 0);
    if (q.size() != 0) begin
      chk(out_addr == q[0][AW-1:0], "out_addr", out_addr, q[0][AW-1:0]);
      chk(out_mode == q[0][AW+2:AW], "out_mode", out_mode, q[0][AW+2:AW]);
    end
    chk(in_ready == (q.size() == 0 || ordy), "in_ready", in_ready, q.size() == 0 || ordy);
    fin = in_valid && in_ready;
    fout = out_valid && out_ready;
    @(posedge clk);
    if (fout && q.size() != 0) void'(q.pop_front());
    if (fin) q.push_back(expect_of(ia, it));
    if (ld) begin
      d = decode(cw);
      mdl_x = d & 15;
      mdl_y = (d >> 4) & 15;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 2'd0, 1, 0, cfg_word);
  endtask

  task automatic load(logic [CW-1:0] w);
    cyc(0, '0, 2'd0, 1, 1, w);
    idle(1);
  endtask

  // sweep all combinations of bits 9, 10, 11, 17 for one tiling kind
  task automatic sweep(logic [1:0] t);
    logic [AW-1:0] a;
    for (int i = 0; i < 16; i++) begin
      a = $urandom;
      a[9] = i[0]; a[10] = i[1]; a[11] = i[2]; a[17] = i[3];
      a[6] = i[0] ^ i[2];
      cyc(1, a, t, 1, 0, cfg_word);
    end
    idle(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    idle(1);
    sweep(2'd1);
    sweep(2'd2);

    tag = "R5";
    load(mkcfg(2, 1, 0, 4, 9));
    sweep(2'd1);
    sweep(2'd2);

    tag = "R3";
    sweep(2'd0);
    sweep(2'd3);

    tag = "R6";
    load(mkcfg(2, 0, 0, 1, 1));
    sweep(2'd1);
    sweep(2'd2);

    tag = "R7";
    load(mkcfg(2, 0, 1, 1, 1));
    sweep(2'd1);
    sweep(2'd2);

    tag = "R4";
    load(mkcfg(0, 1, 0, 5, 5));
    sweep(2'd1);
    sweep(2'd2);
    load(mkcfg(1, 0, 1, 5, 5));
    sweep(2'd1);
    sweep(2'd2);

    tag = "R8";
    load(mkcfg(3, 0, 1, 8'h3c, 8'h3c));
    sweep(2'd1);
    sweep(2'd2);
    load(mkcfg(3, 0, 1, 8'h3c, 8'h3d));
    sweep(2'd1);
    sweep(2'd2);

    tag = "R2";
    load('1);
    sweep(2'd1);
    sweep(2'd2);

    tag = "R9";
    load(mkcfg(2, 0, 0, 0, 0));
    // new word presented without a load: no effect
    cyc(0, '0, 2'd0, 1, 0, mkcfg(0, 0, 0, 0, 0));
    sweep(2'd1);
    // request on the same edge as a load uses the old mode
    cyc(1, 32'h0000_0e00, 2'd1, 1, 1, mkcfg(2, 0, 1, 0, 0));
    cyc(1, 32'h0002_0200, 2'd1, 1, 0, cfg_word);
    idle(2);

    tag = "R10";
    for (int i = 0; i < 12; i++)
      cyc(1, $urandom, 2'd1, (i % 3) == 2, 0, cfg_word);
    for (int i = 0; i < 4; i++) cyc(0, '0, 2'd0, 0, 0, cfg_word);
    idle(2);

    tag = "R11";
    for (int i = 0; i < 24; i++)
      cyc(1, $urandom, 2'(i % 4), 1, 0, cfg_word);
    idle(2);

    tag = "R12";
    load(mkcfg(2, 0, 0, 0, 0));
    for (int i = 0; i < 32; i++) cyc(1, $urandom, 2'(i % 4), 1, 0, cfg_word);
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule